// File: doc/BRIEF.md
# Synchronous Bus Target Interface

This block is the target side of a synchronous 32-bit processor bus. On that bus a cycle opens with a one-clock active-low start strobe and closes with a one-clock active-low acknowledge. The block watches for normal single transfers whose address falls inside a fixed window. It captures the address offset, the direction and the byte lanes that the size field and the low address bits select. After a configurable number of wait states it presents the request to a simple peripheral port and holds it there until the peripheral signals ready. It then acknowledges the master for exactly one clock. On a read, it drives the returned word on the enabled lanes during that same clock.

Addresses outside the window are never answered, so other targets on the bus can claim them. A transfer that the master marks as a burst is handled according to a configuration input. It is either served as an ordinary single transfer or ignored altogether. All inputs are sampled, and all outputs are driven, on the rising edge of the single bus clock. Reset is synchronous and active high.

Top module: `sbus_target`

## Requirements
- R1: While reset is high, and in the first clock after it is released, `bus_ta_n` is 1, `bus_rdata_oe` is 0, `bus_rdata` is zero and `per_req` is 0.
- R2: A cycle is accepted only when `bus_ts_n` and `bus_tip_n` are both sampled low and `bus_addr[31:WIN_BITS]` equals `WIN_BASE[31:WIN_BITS]`. Any other start produces no `per_req` and no acknowledge.
- R3: `per_be` bit 3 enables lane 0 (data bits 31:24) and bit 0 enables lane 3 (bits 7:0). Size 00 (and 11) gives 1111. Size 01 (byte) gives 1000 shifted right by `addr[1:0]`. Size 10 (16-bit) gives 1100 when `addr[1]` is 0 and 0011 when it is 1.
- R4: With `cfg_wait` = N sampled at the accepted start, and the peripheral ready after D cycles of `per_req`, `bus_ta_n` goes low in the clock edge N+2+D edges after the edge that sampled the start.
- R5: `bus_ta_n` is low for exactly one clock per accepted cycle. `bus_rdata_oe` is high only in that clock, and only for reads. Both are released in the next clock.
- R6: On a read, `bus_rdata` during acknowledge equals the peripheral word captured when ready was sampled, with bytes on disabled lanes forced to zero.
- R7: During `per_req`, `per_addr` carries the low `WIN_BITS` address bits of the accepted start. `per_we` is 1 for writes (`bus_rw` = 0) and 0 for reads (`bus_rw` = 1), and `per_wdata` follows `bus_wdata`.
- R8: A start with `bus_burst` = 1 is served as a single transfer when `cfg_burst_single` = 1 and is ignored (no `per_req`, no acknowledge) when it is 0.
- R9: While `per_req` is high and `per_ready` is low, the request stays asserted and `per_addr`, `per_be` and `per_we` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ts_n | input | 1 | Transfer start strobe, active low, one clock |
| bus_tip_n | input | 1 | Transfer in progress, active low |
| bus_addr | input | 32 | Byte address |
| bus_siz | input | 2 | Transfer size: 00 32-bit, 01 8-bit, 10 16-bit |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_burst | input | 1 | Master marks the transfer as a burst |
| bus_wdata | input | 32 | Write data |
| bus_ta_n | output | 1 | Transfer acknowledge, active low, one clock |
| bus_rdata | output | 32 | Read data, zero when not driven |
| bus_rdata_oe | output | 1 | Read-data drive enable |
| cfg_wait | input | WAIT_BITS (4) | Wait states inserted before the peripheral access |
| cfg_burst_single | input | 1 | 1 serves bursts as single transfers, 0 ignores them |
| per_req | output | 1 | Peripheral access request, held until ready |
| per_we | output | 1 | Peripheral write enable |
| per_addr | output | WIN_BITS (16) | Byte offset inside the window |
| per_be | output | 4 | Byte lane enables, bit 3 = bits 31:24 |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data |
| per_ready | input | 1 | Peripheral completes the access |

## Verification
A corrupted sequencer state shows up at the ports in one of two ways. It can produce an acknowledge that no scoreboard entry explains, a second low clock on `bus_ta_n`, or a drive enable left high. The bench catches these at the very next falling edge. A miscounted wait counter or a lost ready shifts the acknowledge off the N+2+D clock. It is caught when the acknowledge arrives, or by the driver's timeout within about 80 clocks. Wrong captured lanes or offsets appear on `per_addr`, `per_be` or `bus_rdata` in the access or acknowledge clock of that same transfer.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACCESS = 2'd2,
        ST_ACK    = 2'd3
    } sbus_state_e;

    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    typedef struct packed {
        logic [3:0] be;
        logic       rd;
    } sbus_req_t;

    // Lane enables, bit 3 = lane 0 = data[31:24]
    function automatic logic [3:0] lane_enables(input logic [1:0] siz, input logic [1:0] a);
        logic [3:0] r;
        case (siz)
            SZ_BYTE: r = 4'b1000 >> a;
            SZ_WORD: r = a[1] ? 4'b0011 : 4'b1100;
            default: r = 4'b1111;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sbus_decode.sv
module sbus_decode
    import sbus_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h4000_0000,
    parameter int          WIN_BITS = 16
) (
    input  logic [31:0] addr,
    input  logic [1:0]  siz,
    input  logic        ts_n,
    input  logic        tip_n,
    input  logic        burst,
    input  logic        burst_single,
    output logic        start,
    output logic [3:0]  be
);
    localparam int TAG_LSB = WIN_BITS;

    logic in_window;
    logic strobe;
    logic kind_ok;

    assign in_window = (addr[31:TAG_LSB] == WIN_BASE[31:TAG_LSB]);
    assign strobe    = !ts_n && !tip_n;
    assign kind_ok   = !burst || burst_single;
    assign start     = strobe && in_window && kind_ok;
    assign be        = lane_enables(siz, addr[1:0]);

endmodule

// File: rtl/sbus_waitgen.sv
module sbus_waitgen #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R4
    wait_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !done) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sbus_rdlane.sv
module sbus_rdlane #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [LANES-1:0]   be,
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                dout[8*i +: 8] <= '0;
            else if (capture)
                dout[8*i +: 8] <= be[i] ? din[8*i +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/sbus_target.sv
module sbus_target
    import sbus_pkg::*;
#(
    parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
    parameter int          WIN_BITS  = 16,
    parameter int          WAIT_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_ts_n,
    input  logic                 bus_tip_n,
    input  logic [31:0]          bus_addr,
    input  logic [1:0]           bus_siz,
    input  logic                 bus_rw,
    input  logic                 bus_burst,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_ta_n,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rdata_oe,
    input  logic [WAIT_BITS-1:0] cfg_wait,
    input  logic                 cfg_burst_single,
    output logic                 per_req,
    output logic                 per_we,
    output logic [WIN_BITS-1:0]  per_addr,
    output logic [3:0]           per_be,
    output logic [31:0]          per_wdata,
    input  logic [31:0]          per_rdata,
    input  logic                 per_ready
);
    localparam int LANES = 4;

    sbus_state_e          state;
    sbus_req_t            req;
    logic [WIN_BITS-1:0]  req_off;
    logic                 start;
    logic [3:0]           dec_be;
    logic                 accept;
    logic                 wait_done;
    logic                 rd_capture;
    logic [31:0]          rd_word;

    sbus_decode #(
        .WIN_BASE (WIN_BASE),
        .WIN_BITS (WIN_BITS)
    ) u_decode (
        .addr         (bus_addr),
        .siz          (bus_siz),
        .ts_n         (bus_ts_n),
        .tip_n        (bus_tip_n),
        .burst        (bus_burst),
        .burst_single (cfg_burst_single),
        .start        (start),
        .be           (dec_be)
    );

    assign accept = start && (state == ST_IDLE);

    sbus_waitgen #(
        .CW (WAIT_BITS)
    ) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (cfg_wait),
        .dec      (state == ST_WAIT),
        .done     (wait_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req     <= '0;
            req_off <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state   <= ST_WAIT;
                        req_off <= bus_addr[WIN_BITS-1:0];
                        req.be  <= dec_be;
                        req.rd  <= bus_rw;
                    end
                end
                ST_WAIT:   if (wait_done) state <= ST_ACCESS;
                ST_ACCESS: if (per_ready) state <= ST_ACK;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign rd_capture = (state == ST_ACCESS) && per_ready;

    sbus_rdlane #(
        .LANES (LANES)
    ) u_rdlane (
        .clk     (clk),
        .rst     (rst),
        .capture (rd_capture),
        .be      (req.be),
        .din     (per_rdata),
        .dout    (rd_word)
    );

    assign bus_ta_n     = (state != ST_ACK);
    assign bus_rdata_oe = (state == ST_ACK) && req.rd;
    assign bus_rdata    = bus_rdata_oe ? rd_word : 32'h0;

    assign per_req   = (state == ST_ACCESS);
    assign per_we    = !req.rd;
    assign per_addr  = req_off;
    assign per_be    = req.be;
    assign per_wdata = bus_wdata;

    // R5
    ta_single_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_ta_n |=> bus_ta_n);

    // R5
    oe_inside_ack_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_oe |-> !bus_ta_n);

    // R4
    ack_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ta_n) |-> $past(per_req && per_ready));

    // R2
    miss_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !bus_ts_n && !bus_tip_n && !start) |=> !per_req && bus_ta_n);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (per_req && !per_ready) |=> per_req && $stable(per_addr) && $stable(per_be) && $stable(per_we));

    // R3
    be_width_chk: assert property (@(posedge clk) disable iff (rst)
        per_req |-> ($countones(per_be) == 1 || $countones(per_be) == 2 || $countones(per_be) == 4));

endmodule

// File: tb/sbus_target_bench.sv
`timescale 1ns/1ps
module sbus_target_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_ts_n, bus_tip_n, bus_rw, bus_burst;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_siz;
    logic        bus_ta_n, bus_rdata_oe;
    logic [3:0]  cfg_wait;
    logic        cfg_burst_single;
    logic        per_req, per_we, per_ready;
    logic [15:0] per_addr;
    logic [3:0]  per_be;
    logic [31:0] per_wdata, per_rdata;

    always #2.5 clk = ~clk;

    sbus_target u_sbus_target (
        .clk (clk), .rst (rst),
        .bus_ts_n (bus_ts_n), .bus_tip_n (bus_tip_n), .bus_addr (bus_addr),
        .bus_siz (bus_siz), .bus_rw (bus_rw), .bus_burst (bus_burst),
        .bus_wdata (bus_wdata), .bus_ta_n (bus_ta_n), .bus_rdata (bus_rdata),
        .bus_rdata_oe (bus_rdata_oe), .cfg_wait (cfg_wait),
        .cfg_burst_single (cfg_burst_single), .per_req (per_req),
        .per_we (per_we), .per_addr (per_addr), .per_be (per_be),
        .per_wdata (per_wdata), .per_rdata (per_rdata), .per_ready (per_ready)
    );

    typedef struct {
        logic        rd;
        logic [15:0] off;
        logic [3:0]  be;
        logic [31:0] wd;
        int          lat;
        int          ts_cyc;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_fail = 0;
    int cyc = 0, acks = 0, reqs = 0, acc_cnt = 0, rdy_delay = 0;
    bit prev_ack = 0, done = 0;

    function automatic logic [31:0] mix(input logic [15:0] off);
        return {off, ~off};
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] siz, input logic [1:0] a);
        if (siz == 2'b01) return 4'b1000 >> a;
        if (siz == 2'b10) return a[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Peripheral model
    always @(posedge clk) begin
        cyc     <= cyc + 1;
        acc_cnt <= per_req ? acc_cnt + 1 : 0;
    end
    assign per_ready = per_req && (acc_cnt >= rdy_delay);
    assign per_rdata = mix({per_addr[15:2], 2'b00});

    // Monitor: pops scoreboard items as the design answers
    always @(negedge clk) begin
        item_t it;
        if (!rst) begin
            if (prev_ack) begin
                chk(bus_ta_n == 1'b1, "R5 ta released", {31'd0, bus_ta_n}, 32'd1);
                chk(bus_rdata_oe == 1'b0, "R5 oe released", {31'd0, bus_rdata_oe}, 32'd0);
            end
            if (per_req && per_ready) begin
                reqs++;
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected peripheral access", {16'd0, per_addr}, 32'd0);
                end else begin
                    it = q[0];
                    chk(per_addr == it.off, "R7 per_addr", {16'd0, per_addr}, {16'd0, it.off});
                    chk(per_be == it.be, "R3 per_be", {28'd0, per_be}, {28'd0, it.be});
                    chk(per_we == !it.rd, "R7 per_we", {31'd0, per_we}, {31'd0, !it.rd});
                    if (!it.rd)
                        chk(per_wdata == it.wd, "R7 per_wdata", per_wdata, it.wd);
                end
            end
            if (!bus_ta_n) begin
                acks++;
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected acknowledge", 32'd0, 32'd1);
                end else begin
                    it = q.pop_front();
                    chk(cyc - it.ts_cyc == it.lat, "R4 latency", cyc - it.ts_cyc, it.lat);
                    chk(bus_rdata_oe == it.rd, "R5 oe on ack", {31'd0, bus_rdata_oe}, {31'd0, it.rd});
                    if (it.rd)
                        chk(bus_rdata == (mix({it.off[15:2], 2'b00}) & exp_mask(it.be)),
                            "R6 read data", bus_rdata, mix({it.off[15:2], 2'b00}) & exp_mask(it.be));
                end
            end
            prev_ack = !bus_ta_n;
        end
    end

    // Driver
    task automatic xfer(input logic rd, input logic [31:0] addr, input logic [1:0] siz,
                        input logic [31:0] wd, input int wn, input int rdl,
                        input logic burst, input logic hit, input string tag);
        int    a0, r0;
        item_t it;
        @(negedge clk);
        cfg_wait  = wn[3:0];
        rdy_delay = rdl;
        bus_addr  = addr;
        bus_siz   = siz;
        bus_rw    = rd;
        bus_burst = burst;
        bus_wdata = wd;
        bus_ts_n  = 1'b0;
        bus_tip_n = 1'b0;
        a0 = acks;
        r0 = reqs;
        if (hit) begin
            it.rd = rd; it.off = addr[15:0]; it.be = exp_be(siz, addr[1:0]);
            it.wd = wd; it.lat = wn + 2 + rdl; it.ts_cyc = cyc + 1;
            q.push_back(it);
        end
        @(negedge clk);
        bus_ts_n = 1'b1;
        if (hit) begin
            for (int i = 0; i < 80 && acks == a0; i++) @(negedge clk);
            chk(acks == a0 + 1, {tag, " acknowledge count"}, acks - a0, 1);
        end else begin
            repeat (20) @(negedge clk);
            chk(acks == a0, {tag, " no acknowledge"}, acks - a0, 0);
            chk(reqs == r0, {tag, " no peripheral access"}, reqs - r0, 0);
        end
        @(negedge clk);
        bus_tip_n = 1'b1;
        bus_burst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        bus_ts_n = 1'b1; bus_tip_n = 1'b1; bus_rw = 1'b1; bus_burst = 1'b0;
        bus_addr = '0; bus_wdata = '0; bus_siz = 2'b00;
        cfg_wait = '0; cfg_burst_single = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_ta_n == 1'b1, "R1 ta in reset", {31'd0, bus_ta_n}, 32'd1);
        chk(bus_rdata_oe == 1'b0, "R1 oe in reset", {31'd0, bus_rdata_oe}, 32'd0);
        chk(per_req == 1'b0, "R1 req in reset", {31'd0, per_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_ta_n == 1'b1 && bus_rdata == 32'h0, "R1 after reset", bus_rdata, 32'h0);

        xfer(1'b1, 32'h4000_0010, 2'b00, 32'h0, 0, 0, 1'b0, 1'b1, "R4");
        xfer(1'b0, 32'h4000_0024, 2'b00, 32'hCAFE_F00D, 3, 0, 1'b0, 1'b1, "R7");
        for (int k = 0; k < 4; k++)
            xfer(1'b1, 32'h4000_0130 + k, 2'b01, 32'h0, 1, 0, 1'b0, 1'b1, "R3");
        xfer(1'b1, 32'h4000_0202, 2'b10, 32'h0, 0, 1, 1'b0, 1'b1, "R3");
        xfer(1'b1, 32'h4000_0200, 2'b10, 32'h0, 2, 0, 1'b0, 1'b1, "R3");
        xfer(1'b0, 32'h4000_0305, 2'b01, 32'h1122_3344, 0, 2, 1'b0, 1'b1, "R9");
        xfer(1'b1, 32'h4000_FFFC, 2'b00, 32'h0, 15, 3, 1'b0, 1'b1, "R4");
        xfer(1'b1, 32'h5000_0010, 2'b00, 32'h0, 0, 0, 1'b0, 1'b0, "R2");
        xfer(1'b0, 32'h3FFF_FFFC, 2'b00, 32'h5555_AAAA, 0, 0, 1'b0, 1'b0, "R2");
        cfg_burst_single = 1'b0;
        xfer(1'b1, 32'h4000_0040, 2'b00, 32'h0, 0, 0, 1'b1, 1'b0, "R8");
        cfg_burst_single = 1'b1;
        xfer(1'b1, 32'h4000_0040, 2'b00, 32'h0, 1, 0, 1'b1, 1'b1, "R8");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R5 scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule